// File: doc/BRIEF.md
# Branch Target and Link Sequencer

This block steers the three cycles that a branch or branch-with-link occupies in a three-stage core, where the program counter value seen by an executing instruction is the branch's own address plus eight. A one-cycle start pulse hands it the branch instruction word and the current r15 value. Both are captured at once. In the following three cycles the block issues the branch target as a fetch request, holds a flush line high while the instruction pipeline refills, and for a linking branch writes the return address into r14.

The link write takes two steps. In the second cycle r14 receives the raw r15 value. In the third cycle that value is overwritten with r15 minus four, the address of the instruction that follows the branch. One cycle after the third cycle a done pulse tells the surrounding core that the sequence is over. Condition evaluation, the register file and the instruction memory are outside the block.

Top module: `bt_branch_seq`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, fetch_req_o, lr_we_o, flush_o and done_o are low, and fetch_addr_o and lr_wdata_o read zero.
- R2: A start_i pulse sampled while the block is idle begins a sequence. Cycle 1 is the cycle after that clock edge, and cycle 2 and cycle 3 follow it. fetch_req_o is high in cycle 1 only.
- R3: In cycle 1, fetch_addr_o equals the captured r15 plus instruction bits [23:0], sign-extended and shifted left by two, taken modulo 2^32. Outside cycle 1, fetch_addr_o reads zero.
- R4: flush_o is high in cycles 1, 2 and 3 and low at every other time.
- R5: When instruction bit 24 (the link bit) is set, lr_we_o is high in cycle 2 and lr_wdata_o equals the captured r15.
- R6: When the link bit is set, lr_we_o is high in cycle 3 and lr_wdata_o equals the captured r15 minus 4, modulo 2^32.
- R7: When the link bit is clear, lr_we_o stays low in cycles 2 and 3. Whenever lr_we_o is low, lr_wdata_o reads zero.
- R8: done_o is high for exactly the one cycle after cycle 3.
- R9: A start_i pulse during cycles 1 to 3 is ignored. The running sequence keeps its original operands, and no new sequence follows it.
- R10: Changes on instr_i and r15_i after the start edge have no effect on the running sequence.
- R11: A start_i pulse sampled in the done cycle is accepted. The new cycle 1 immediately follows the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a branch sequence (sampled when idle) |
| instr_i | input | 32 | Branch instruction word; [23:0] offset, [24] link |
| r15_i | input | 32 | Current r15 value (branch address plus 8) |
| fetch_addr_o | output | 32 | Branch target fetch address |
| fetch_req_o | output | 1 | Fetch strobe for the target |
| lr_we_o | output | 1 | Write enable for r14 |
| lr_wdata_o | output | 32 | Data for r14 |
| flush_o | output | 1 | Discard instructions fetched before the target |
| done_o | output | 1 | One-cycle pulse after the sequence ends |

## Verification
The bench uses negative offsets and a target that wraps past 2^32. A design that shifts before sign-extending, or that leaves the field unsigned, would jump forward by megabytes instead of backward. It compares the two r14 writes of a linking branch against each other. A design that skips the third-cycle correction would leave the link pointing one word too far, and one that writes the link for a plain branch would corrupt r14. It also pulses start mid-sequence, changes the operand inputs after the start edge, and issues a second branch right in the done cycle. A design that rearms while busy, reads live inputs, or stays busy one cycle too long shows a wrong fetch address, a wrong link value or a missing fetch strobe.

// File: rtl/bt_pkg.sv
// Package: shared types for the branch sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package bt_pkg;

    // Phase of a branch sequence: idle, target issue, link write, link fix.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TGT  = 2'd1,
        ST_LINK = 2'd2,
        ST_FIX  = 2'd3
    } bt_state_e;

endpackage

// File: rtl/bt_seq_ctrl.sv
// Module: bt_seq_ctrl
// Walks the three branch cycles after an accepted start and raises a done
// pulse in the cycle after the last one.
// Assumes: start is only honoured while idle; reset is synchronous, active low.
module bt_seq_ctrl
    import bt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    output bt_state_e state_o,
    output logic      accept_o,
    output logic      done_o
);

    bt_state_e state_q;
    bt_state_e state_d;
    logic      done_q;

    // Accept a start only when no sequence is running.
    always_comb begin
        accept_o = start_i && (state_q == ST_IDLE);
    end

    // Next phase: idle -> target -> link -> fix -> idle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept_o) state_d = ST_TGT;
            ST_TGT:  state_d = ST_LINK;
            ST_LINK: state_d = ST_FIX;
            ST_FIX:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Done pulse: one cycle, following the fix phase.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_FIX);
    end

    assign state_o = state_q;
    assign done_o  = done_q;

endmodule

// File: rtl/bt_target_calc.sv
// Module: bt_target_calc
// Forms the branch target: base plus the signed offset field scaled to words.
// Assumes: ADDR_W > OFF_W + SHIFT; the sum wraps modulo 2^ADDR_W.
module bt_target_calc #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 24,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  field_i,
    output logic [ADDR_W-1:0] target_o
);

    localparam int EXT_W = ADDR_W - OFF_W - SHIFT;

    logic [ADDR_W-1:0] offset;

    // Sign-extend the field first, then append the word-alignment zeros.
    always_comb begin
        offset   = {{EXT_W{field_i[OFF_W-1]}}, field_i, {SHIFT{1'b0}}};
        target_o = base_i + offset;
    end

endmodule

// File: rtl/bt_link_calc.sv
// Module: bt_link_calc
// Produces the r14 value: the raw base in the link phase, and the base
// stepped back one instruction in the fix phase.
// Assumes: STEP is the distance between r15 and the next instruction.
module bt_link_calc #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              fix_i,
    output logic [ADDR_W-1:0] link_o
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Choose raw or corrected return address.
    always_comb begin
        link_o = fix_i ? (base_i - STEP_V) : base_i;
    end

endmodule

// File: rtl/bt_branch_seq.sv
// Module: bt_branch_seq (top)
// Three-cycle branch sequencer. It captures the branch word and r15 on start.
// It issues the target fetch in cycle 1 and flushes through cycle 3. For a
// linking branch it writes r14 in cycle 2 and corrects it in cycle 3. Done
// follows in the next cycle.
// Assumes: r15 reads as the branch address plus 8; condition already passed.
module bt_branch_seq #(
    parameter int ADDR_W    = 32,
    parameter int INSTR_W   = 32,
    parameter int OFF_W     = 24,
    parameter int SHIFT     = 2,
    parameter int LINK_BIT  = 24,
    parameter int LINK_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [ADDR_W-1:0]  r15_i,
    output logic [ADDR_W-1:0]  fetch_addr_o,
    output logic               fetch_req_o,
    output logic               lr_we_o,
    output logic [ADDR_W-1:0]  lr_wdata_o,
    output logic               flush_o,
    output logic               done_o
);
    import bt_pkg::*;

    bt_state_e         state;
    logic              accept;
    logic [OFF_W-1:0]  field_q;
    logic              link_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] link_val;

    bt_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .state_o  (state),
        .accept_o (accept),
        .done_o   (done_o)
    );

    // Operand capture on an accepted start; held for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
            link_q  <= 1'b0;
            base_q  <= '0;
        end else if (accept) begin
            field_q <= instr_i[OFF_W-1:0];
            link_q  <= instr_i[LINK_BIT];
            base_q  <= r15_i;
        end
    end

    bt_target_calc #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .SHIFT  (SHIFT)
    ) u_tgt (
        .base_i   (base_q),
        .field_i  (field_q),
        .target_o (target)
    );

    bt_link_calc #(
        .ADDR_W (ADDR_W),
        .STEP   (LINK_STEP)
    ) u_link (
        .base_i (base_q),
        .fix_i  (state == ST_FIX),
        .link_o (link_val)
    );

    // Output decode per phase; data buses read zero when not strobed.
    always_comb begin
        fetch_req_o  = (state == ST_TGT);
        fetch_addr_o = fetch_req_o ? target : '0;
        flush_o      = (state != ST_IDLE);
        lr_we_o      = link_q && ((state == ST_LINK) || (state == ST_FIX));
        lr_wdata_o   = lr_we_o ? link_val : '0;
    end

endmodule

// File: rtl/bt_branch_seq_chk.sv
// Module: bt_branch_seq_chk
// Temporal checks on the sequencer's ports, attached by bind.
// Assumes: synchronous active-low reset.
module bt_branch_seq_chk #(
    parameter int ADDR_W    = 32,
    parameter int LINK_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] r15_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic              fetch_req_o,
    input logic              lr_we_o,
    input logic [ADDR_W-1:0] lr_wdata_o,
    input logic              flush_o,
    input logic              done_o
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(LINK_STEP);

    // R2
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |=> !fetch_req_o);

    // R3
    target_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> (fetch_addr_o[1:0] == $past(r15_i[1:0])));

    // R4
    flush_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_o) |-> fetch_req_o);

    // R4
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |=> flush_o);

    // R6
    link_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we_o && $past(lr_we_o)) |-> (lr_wdata_o == $past(lr_wdata_o) - STEP_V));

    // R7
    link_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we_o |-> (flush_o && !fetch_req_o));

    // R8
    done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(flush_o) && !flush_o));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind bt_branch_seq bt_branch_seq_chk #(
    .ADDR_W    (ADDR_W),
    .LINK_STEP (LINK_STEP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .r15_i        (r15_i),
    .fetch_addr_o (fetch_addr_o),
    .fetch_req_o  (fetch_req_o),
    .lr_we_o      (lr_we_o),
    .lr_wdata_o   (lr_wdata_o),
    .flush_o      (flush_o),
    .done_o       (done_o)
);

// File: tb/bt_branch_seq_tb.sv
module bt_branch_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] r15_i = '0;
    logic [31:0] fetch_addr_o;
    logic        fetch_req_o;
    logic        lr_we_o;
    logic [31:0] lr_wdata_o;
    logic        flush_o;
    logic        done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bt_branch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .r15_i(r15_i), .fetch_addr_o(fetch_addr_o), .fetch_req_o(fetch_req_o),
        .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o), .flush_o(flush_o),
        .done_o(done_o)
    );

    // Vectors: {instr, r15}. Bit 24 is the link bit, [23:0] the offset.
    localparam int NV = 6;
    localparam logic [63:0] VEC [NV] = '{
        {32'hEA00_0010, 32'h0000_1008},   // plain, forward
        {32'hEB00_0003, 32'h0000_2008},   // link, forward
        {32'hEAFF_FFFE, 32'h0000_0108},   // plain, -2 words
        {32'hEB80_0000, 32'h0400_0008},   // link, most negative offset
        {32'hEB7F_FFFF, 32'hFFFF_FF08},   // link, wraps past 2^32
        {32'hEA00_0000, 32'h8000_0000}    // plain, zero offset
    };

    function automatic logic [31:0] exp_target(logic [31:0] ins, logic [31:0] pc);
        logic [31:0] off;
        off = {{6{ins[23]}}, ins[23:0], 2'b00};
        return pc + off;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample the three cycles and the done cycle of a sequence started at
    // the current negedge. midstart pulses start in cycle 2; scramble changes
    // inputs after the start edge.
    task automatic run_seq(logic [31:0] ins, logic [31:0] pc, bit midstart, bit scramble);
        bit lnk;
        lnk = ins[24];
        start_i = 1'b1; instr_i = ins; r15_i = pc;
        @(negedge clk);
        start_i = 1'b0;
        if (scramble) begin instr_i = ~ins; r15_i = pc ^ 32'h5555_0000; end
        // cycle 1
        chk("R2 fetch_req c1", 32'(fetch_req_o), 1);
        chk("R3 target", fetch_addr_o, exp_target(ins, pc));
        chk("R4 flush c1", 32'(flush_o), 1);
        chk("R7 no lr c1", 32'(lr_we_o), 0);
        @(negedge clk);
        if (midstart) begin start_i = 1'b1; instr_i = 32'hEB00_0100; r15_i = 32'h1234_5678; end
        // cycle 2
        chk("R2 fetch_req c2", 32'(fetch_req_o), 0);
        chk("R4 flush c2", 32'(flush_o), 1);
        if (lnk) begin
            chk("R5 lr_we c2", 32'(lr_we_o), 1);
            chk("R5 lr data c2", lr_wdata_o, pc);
        end else begin
            chk("R7 lr_we c2", 32'(lr_we_o), 0);
            chk("R7 lr data c2", lr_wdata_o, 0);
        end
        @(negedge clk);
        start_i = 1'b0;
        // cycle 3
        chk("R4 flush c3", 32'(flush_o), 1);
        chk("R3 addr zero c3", fetch_addr_o, 0);
        if (lnk) begin
            chk("R6 lr_we c3", 32'(lr_we_o), 1);
            chk("R6 lr data c3", lr_wdata_o, pc - 32'd4);
        end else begin
            chk("R7 lr_we c3", 32'(lr_we_o), 0);
        end
        @(negedge clk);
        // done cycle
        chk("R8 done", 32'(done_o), 1);
        chk("R4 flush off", 32'(flush_o), 0);
        chk("R7 lr off", 32'(lr_we_o), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        start_i = 1'b1; instr_i = 32'hEB00_0001; r15_i = 32'h100;
        repeat (3) @(negedge clk);
        chk("R1 fetch_req rst", 32'(fetch_req_o), 0);
        chk("R1 flush rst", 32'(flush_o), 0);
        chk("R1 lr_we rst", 32'(lr_we_o), 0);
        chk("R1 done rst", 32'(done_o), 0);
        chk("R1 addr rst", fetch_addr_o, 0);
        chk("R1 lr data rst", lr_wdata_o, 0);
        start_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after rst", 32'(flush_o), 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            run_seq(VEC[i][63:32], VEC[i][31:0], 1'b0, 1'b0);
            @(negedge clk);
            chk("R8 done single", 32'(done_o), 0);
        end

        // R10: inputs changed after start edge
        run_seq(32'hEB00_0040, 32'h0000_3008, 1'b0, 1'b1);
        @(negedge clk);

        // R9: start pulse mid-sequence ignored, no trailing sequence
        run_seq(32'hEBFF_FFF0, 32'h0000_4008, 1'b1, 1'b0);
        @(negedge clk);
        chk("R9 no rearm fetch", 32'(fetch_req_o), 0);
        chk("R9 no rearm flush", 32'(flush_o), 0);
        @(negedge clk);
        chk("R9 still idle", 32'(flush_o), 0);

        // R11: back-to-back start in the done cycle
        run_seq(32'hEA00_0008, 32'h0000_5008, 1'b0, 1'b0);
        run_seq(32'hEB00_0002, 32'h0000_6008, 1'b0, 1'b0);
        chk("R11 second seq done", 32'(done_o), 1);
        @(negedge clk);
        chk("R8 idle after", 32'(flush_o), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule